// File: doc/BRIEF.md
# Programmable Multi-State Trigger Sequencer

This block decides when a logic capture fires its trigger. It steps through up to sixteen programmed states. In each state it evaluates three conditions from the live trigger terms and from two internal timers. The *hit* condition moves the machine forward, the *else* condition sends it to a programmed target state, and the *capture* condition qualifies which samples are stored. The trigger terms are computed outside the block and arrive as a flat vector each clock.

Each condition is a three-level table tree, and each level is a 16-entry truth table:
- Eight pair tables each read four condition bits.
- Two middle tables each read four pair results.
- One final table reads the two middle results.

Each state also has a control word with these fields: an occurrence count, an else target, start/stop/clear actions for the two timers, a fire flag and a last flag. All configuration goes through a select register followed by data writes.

Software first issues an abort (or a reset) and then writes the configuration. It then pulses arm. The run ends when a state that carries the last flag advances. The term inputs and the status outputs are plain per-cycle signals. The block takes no back-pressure and applies none.

Top module: `trig_seq_top`

## Requirements
- R1: After reset, run_o, trig_o, cap_o and tmr_done_o are 0 and state_o is 0.
- R2: After writing select value n (0..15), one data write loads the control word of state n, with this bit layout:
  - bit 31: last
  - bit 30: fire
  - bits 29:28: start timer 1/0
  - bits 27:26: clear timer 1/0
  - bits 25:24: stop timer 1/0
  - bits 23:20: else target
  - bits 19:0: occurrence count
- R3: A condition is evaluated in three levels, with condition bits cond = {timer1 done, timer0 done, term_i[29:0]}:
  - Pair table p outputs its bit at index cond[4p+3:4p].
  - Middle table 1 is indexed by pair results {p3,p2,p1,p0`}` and middle table 2 by {p7,p6,p5,p4}.
  - The final table is indexed by {mid2,mid1}.
  - cap_o is the capture condition of the current state while running, and 0 when idle.
- R4: A state advances only when its hit condition is true at a clock edge on which occurrence-count hits have already been counted. It advances on hit number count+1.
- R5: When hit is false and else is true, the machine goes to the else target and restarts occurrence counting. Hit takes precedence over else. With neither true, the state holds. An advancing hit from state 15 wraps to state 0.
- R6: An advancing hit in a state with the fire flag drives trig_o high for exactly the next cycle. If that state has the last flag, run_o falls and state_o holds.
- R7: Each timer's limit is loaded through selects 0x38+2k (low word) and 0x39+2k (high word). The timer's start, stop and clear actions are applied on an advancing hit. A running timer counts once per clock. Its done flag rises one cycle after the count equals the limit, and it holds until a clear.
- R8: arm_i starts a run in state 0 only if an abort or a reset came after the last arm; otherwise arm_i is ignored. abort_i stops the run, returns to state 0, and stops and clears both timers.
- R9: The sum of state n, term t (0 hit, 1 else, 2 capture) is selected at 0x40+4n+t. It takes six data words in this order:
  - word 0: final table (low 16 bits)
  - word 1: {mid2, mid1}
  - word 2: {p7, p6}
  - word 3: {p5, p4}
  - word 4: {p3, p2}
  - word 5: {p1, p0}

  Further words after the sixth, and any write to t=3, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears all configuration |
| cfg_sel_we | input | 1 | Load the select register |
| cfg_sel | input | 8 | Select value |
| cfg_dat_we | input | 1 | Write one data word to the selected target |
| cfg_dat | input | 32 | Configuration data word |
| arm_i | input | 1 | Start a run (only after abort or reset) |
| abort_i | input | 1 | Stop the run and clear the timers |
| term_i | input | 30 | Trigger term bits from outside |
| trig_o | output | 1 | One-cycle trigger pulse |
| cap_o | output | 1 | Capture qualifier for the current sample |
| run_o | output | 1 | Sequence is running |
| state_o | output | 4 | Current state index |
| tmr_done_o | output | 2 | Timer done flags |

## Verification
The hardest situation to reach is a timer's done flag feeding back into the pair table that waits on it. That table is pair 7, which reads the two timer bits above the term inputs. Reaching it needs a state that starts the timer on an immediate hit, a following state whose hit waits on timer 0, and a count that runs the exact programmed length. The stimulus builds exactly that two-state program with a limit of ten and counts the cycles from arm to trigger. Occurrence counting and else jumps each get their own short program. The table tree is swept from a vector list that rewrites one capture sum per vector.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int NUM_ST    = 16;
  localparam int ST_W      = 4;
  localparam int NUM_COND  = 3;   // hit, else, capture
  localparam int SUM_WORDS = 6;
  localparam int NUM_TMR   = 2;
  localparam int TERM_W    = 30;
  localparam int COND_W    = TERM_W + NUM_TMR;
  localparam int PAIRS     = COND_W / 4;
  localparam int OCC_W     = 20;
  localparam int NSUM      = NUM_ST * 4;
  localparam logic [7:0] SEL_TMR = 8'h38;

  typedef struct packed {
    logic             last;
    logic             fire;
    logic [1:0]       start;
    logic [1:0]       clr;
    logic [1:0]       stop;
    logic [ST_W-1:0]  else_st;
    logic [OCC_W-1:0] occ;
  } st_word_t;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_seq_pkg::*;
(
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    sel_we_i,
  input  logic [7:0]                              sel_i,
  input  logic                                    dat_we_i,
  input  logic [31:0]                             dat_i,
  input  logic [ST_W-1:0]                         cur_st_i,
  output st_word_t                                st_o,
  output logic [NUM_COND-1:0][SUM_WORDS-1:0][31:0] sum_o,
  output logic [NUM_TMR-1:0][63:0]                lim_o
);
  logic [7:0]  sel_q;
  logic [2:0]  widx_q;
  st_word_t    st_mem  [NUM_ST];
  logic [31:0] sum_mem [NSUM][SUM_WORDS];
  logic [NUM_TMR-1:0][63:0] lim_q;

  logic is_st, is_tmr, is_sum;
  assign is_st  = sel_q < 8'(NUM_ST);
  assign is_tmr = sel_q[7:2] == SEL_TMR[7:2];
  assign is_sum = (sel_q[7:6] == 2'b01) && (sel_q[1:0] != 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      widx_q <= '0;
      lim_q  <= '0;
      for (int s = 0; s < NUM_ST; s++) st_mem[s] <= '0;
      for (int i = 0; i < NSUM; i++)
        for (int w = 0; w < SUM_WORDS; w++) sum_mem[i][w] <= '0;
    end else if (sel_we_i) begin
      sel_q  <= sel_i;
      widx_q <= '0;
    end else if (dat_we_i) begin
      if (is_st) begin
        st_mem[sel_q[ST_W-1:0]] <= st_word_t'(dat_i);
      end else if (is_tmr) begin
        if (sel_q[0]) lim_q[sel_q[1]][63:32] <= dat_i;
        else          lim_q[sel_q[1]][31:0]  <= dat_i;
      end else if (is_sum && (widx_q < 3'(SUM_WORDS))) begin
        sum_mem[sel_q[5:0]][widx_q] <= dat_i;
        widx_q <= widx_q + 3'd1;
      end
    end
  end

  always_comb begin
    st_o = st_mem[cur_st_i];
    for (int t = 0; t < NUM_COND; t++)
      for (int w = 0; w < SUM_WORDS; w++)
        sum_o[t][w] = sum_mem[{cur_st_i, 2'(t)}][w];
  end

  assign lim_o = lim_q;

  assert_widx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    widx_q <= 3'(SUM_WORDS));
endmodule

// File: rtl/trig_sum_tree.sv
module trig_sum_tree
  import trig_seq_pkg::*;
(
  input  logic [SUM_WORDS-1:0][31:0] cfg_i,
  input  logic [COND_W-1:0]          cond_i,
  output logic                       hit_o
);
  logic [PAIRS-1:0] pr;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int WI = SUM_WORDS - 1 - (p / 2);
    localparam int HI = p % 2;
    logic [15:0] tab;
    assign tab   = cfg_i[WI][16*HI +: 16];
    assign pr[p] = tab[cond_i[4*p +: 4]];
  end

  logic [15:0] m1t, m2t;
  logic        m1, m2;
  assign m1t   = cfg_i[1][15:0];
  assign m2t   = cfg_i[1][31:16];
  assign m1    = m1t[pr[3:0]];
  assign m2    = m2t[pr[7:4]];
  assign hit_o = cfg_i[0][{3'b000, m2, m1}];
endmodule

// File: rtl/trig_timer.sv
module trig_timer #(
  parameter int TMR_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clr_i,
  input  logic [TMR_W-1:0] lim_i,
  output logic             done_o
);
  logic             run_q, done_q;
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (start_i)     run_q <= 1'b1;
      else if (stop_i) run_q <= 1'b0;
      if (clr_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (run_q && !done_q) begin
        if (cnt_q == lim_i) done_q <= 1'b1;
        else                cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_i) |=> done_q);
  assert_idle_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top
  import trig_seq_pkg::*;
#(
  parameter int TMR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel_we,
  input  logic [7:0]        cfg_sel,
  input  logic              cfg_dat_we,
  input  logic [31:0]       cfg_dat,
  input  logic              arm_i,
  input  logic              abort_i,
  input  logic [TERM_W-1:0] term_i,
  output logic              trig_o,
  output logic              cap_o,
  output logic              run_o,
  output logic [ST_W-1:0]   state_o,
  output logic [NUM_TMR-1:0] tmr_done_o
);
  st_word_t                                 cur;
  logic [NUM_COND-1:0][SUM_WORDS-1:0][31:0] sums;
  logic [NUM_TMR-1:0][63:0]                 lims;
  logic [NUM_COND-1:0]                      cres;
  logic [NUM_TMR-1:0]                       tdone;
  logic [COND_W-1:0]                        cond;

  logic             run_q, primed_q, trig_q;
  logic [ST_W-1:0]  state_q;
  logic [OCC_W-1:0] occ_q;
  logic             adv;

  trig_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n),
    .sel_we_i(cfg_sel_we), .sel_i(cfg_sel),
    .dat_we_i(cfg_dat_we), .dat_i(cfg_dat),
    .cur_st_i(state_q), .st_o(cur), .sum_o(sums), .lim_o(lims)
  );

  assign cond = {tdone, term_i};

  for (genvar t = 0; t < NUM_COND; t++) begin : g_sum
    trig_sum_tree u_tree (.cfg_i(sums[t]), .cond_i(cond), .hit_o(cres[t]));
  end

  assign adv = run_q && cres[0] && (occ_q == cur.occ);

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    trig_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .start_i(adv && cur.start[k] && !abort_i),
      .stop_i (abort_i || (adv && cur.stop[k])),
      .clr_i  (abort_i || (adv && cur.clr[k])),
      .lim_i  (lims[k][TMR_W-1:0]),
      .done_o (tdone[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      primed_q <= 1'b1;
      trig_q   <= 1'b0;
      state_q  <= '0;
      occ_q    <= '0;
    end else begin
      trig_q <= 1'b0;
      if (abort_i) begin
        run_q    <= 1'b0;
        primed_q <= 1'b1;
        state_q  <= '0;
        occ_q    <= '0;
      end else if (arm_i && primed_q) begin
        run_q    <= 1'b1;
        primed_q <= 1'b0;
        state_q  <= '0;
        occ_q    <= '0;
      end else if (run_q) begin
        if (cres[0]) begin
          if (adv) begin
            occ_q  <= '0;
            trig_q <= cur.fire;
            if (cur.last) run_q   <= 1'b0;
            else          state_q <= state_q + 1'b1;
          end else begin
            occ_q <= occ_q + 1'b1;
          end
        end else if (cres[1]) begin
          state_q <= cur.else_st;
          occ_q   <= '0;
        end
      end
    end
  end

  assign trig_o     = trig_q;
  assign cap_o      = run_q && cres[2];
  assign run_o      = run_q;
  assign state_o    = state_q;
  assign tmr_done_o = tdone;

  assert_trig_from_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(run_q));
  assert_arm_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (state_q == '0 && occ_q == '0));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !arm_i && !abort_i) |=> $stable(state_q));
  assert_no_pulse_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !arm_i) |=> !trig_o);
endmodule

// File: tb/tb_trig_seq_top.sv
`timescale 1ns/1ps
module tb_trig_seq_top;
  logic        clk = 0;
  logic        rst_n;
  logic        cfg_sel_we, cfg_dat_we, arm_i, abort_i;
  logic [7:0]  cfg_sel;
  logic [31:0] cfg_dat;
  logic [29:0] term_i;
  logic        trig_o, cap_o, run_o;
  logic [3:0]  state_o;
  logic [1:0]  tmr_done_o;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  trig_seq_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_sel_we(cfg_sel_we), .cfg_sel(cfg_sel),
    .cfg_dat_we(cfg_dat_we), .cfg_dat(cfg_dat), .arm_i(arm_i), .abort_i(abort_i),
    .term_i(term_i), .trig_o(trig_o), .cap_o(cap_o), .run_o(run_o),
    .state_o(state_o), .tmr_done_o(tmr_done_o)
  );

  typedef struct packed {
    logic [15:0] p0, p4, m1, m2, fin;
    logic [3:0]  t0, t4;
    logic        ex;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{16'h8000, 16'hFFFF, 16'h8000, 16'h8000, 16'h0008, 4'hF, 4'h0, 1'b1},
    '{16'h8000, 16'hFFFF, 16'h8000, 16'h8000, 16'h0008, 4'hE, 4'h0, 1'b0},
    '{16'h8888, 16'hFFFF, 16'h8000, 16'h8000, 16'h0008, 4'h3, 4'h0, 1'b1},
    '{16'h8888, 16'hFFFF, 16'h8000, 16'h8000, 16'h0008, 4'hC, 4'h0, 1'b0},
    '{16'hF888, 16'hFFFF, 16'h8000, 16'h8000, 16'h0008, 4'hC, 4'h0, 1'b1},
    '{16'hF888, 16'hFFFF, 16'h8000, 16'h8000, 16'h0008, 4'h5, 4'h0, 1'b0},
    '{16'h0000, 16'h8000, 16'h8000, 16'h8000, 16'h000E, 4'h0, 4'hF, 1'b1},
    '{16'hFFFF, 16'h8000, 16'h8000, 16'h8000, 16'h0006, 4'h0, 4'hF, 1'b0},
    '{16'hFFFF, 16'h8000, 16'h8000, 16'h8000, 16'h0006, 4'h0, 4'h0, 1'b1},
    '{16'h0000, 16'hFFFF, 16'hFFFE, 16'h8000, 16'h0008, 4'h0, 4'h0, 1'b1},
    '{16'h0000, 16'hFFFF, 16'h8000, 16'h8000, 16'h0008, 4'h0, 4'h0, 1'b0},
    '{16'hFFFF, 16'hFFFF, 16'h8000, 16'h8000, 16'h0000, 4'h0, 4'h0, 1'b0}
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hw_reset();
    rst_n = 0; cfg_sel_we = 0; cfg_dat_we = 0; arm_i = 0; abort_i = 0;
    cfg_sel = 0; cfg_dat = 0; term_i = 0;
    tick(3);
    rst_n = 1;
  endtask

  task automatic wsel(input logic [7:0] v);
    cfg_sel = v; cfg_sel_we = 1; tick(1); cfg_sel_we = 0;
  endtask

  task automatic wdat(input logic [31:0] d);
    cfg_dat = d; cfg_dat_we = 1; tick(1); cfg_dat_we = 0;
  endtask

  task automatic set_sum(input logic [7:0] sel, input logic [31:0] w0, w1, w2, w3, w4, w5);
    wsel(sel); wdat(w0); wdat(w1); wdat(w2); wdat(w3); wdat(w4); wdat(w5);
  endtask

  task automatic do_arm();
    arm_i = 1; tick(1); arm_i = 0;
  endtask

  task automatic do_abort();
    abort_i = 1; tick(1); abort_i = 0;
  endtask

  initial begin
    #(8 * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int k_trig;
    logic d11, d12;

    // R1 reset state
    hw_reset();
    chk("R1 run_o", run_o, 0);
    chk("R1 trig_o", trig_o, 0);
    chk("R1 cap_o", cap_o, 0);
    chk("R1 state_o", state_o, 0);
    chk("R1 tmr_done_o", tmr_done_o, 0);

    // R3/R9 table tree vectors on state 0 capture sum
    for (int i = 0; i < 12; i++) begin
      hw_reset();
      set_sum(8'h42, {16'h0, VEC[i].fin}, {VEC[i].m2, VEC[i].m1}, 32'hFFFF_FFFF,
              {16'hFFFF, VEC[i].p4}, 32'hFFFF_FFFF, {16'hFFFF, VEC[i].p0});
      wdat(32'h0);  // seventh word ignored (R9)
      set_sum(8'h43, 0, 0, 0, 0, 0, 0);  // t=3 ignored (R9)
      term_i = '0;
      term_i[3:0]   = VEC[i].t0;
      term_i[19:16] = VEC[i].t4;
      chk("R3 cap_o idle", cap_o, 0);
      do_arm();
      chk($sformatf("R3 R9 vector %0d cap_o", i), cap_o, VEC[i].ex);
    end

    // R2 R4 R6 occurrence count and last/fire
    hw_reset();
    wsel(8'h00); wdat(32'h0000_0002);
    wsel(8'h01); wdat(32'hC000_0000);
    set_sum(8'h40, 32'h8, 32'h8000_8000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_8000);
    set_sum(8'h44, 32'hFFFF, 0, 0, 0, 0, 0);
    term_i = 30'hF;
    do_arm();
    chk("R8 run after arm", run_o, 1);
    tick(2);
    chk("R4 state before count+1 hits", state_o, 0);
    tick(1);
    chk("R4 R2 state after count+1 hits", state_o, 1);
    chk("R6 no trigger yet", trig_o, 0);
    tick(1);
    chk("R6 trigger pulse", trig_o, 1);
    chk("R6 last ends run", run_o, 0);
    chk("R6 state held", state_o, 1);
    tick(1);
    chk("R6 pulse one cycle", trig_o, 0);

    // R5 else jump, hit precedence, hold
    hw_reset();
    wsel(8'h00); wdat(32'h0050_0000);
    set_sum(8'h41, 32'hFFFF, 0, 0, 0, 0, 0);
    wsel(8'h05); wdat(32'h0090_0000);
    set_sum(8'h54, 32'hFFFF, 0, 0, 0, 0, 0);
    set_sum(8'h55, 32'hFFFF, 0, 0, 0, 0, 0);
    do_arm();
    tick(1);
    chk("R5 else target", state_o, 5);
    tick(1);
    chk("R5 hit over else", state_o, 6);
    tick(2);
    chk("R5 hold without hit or else", state_o, 6);

    // R7 R10-style timer feedback through pair 7
    hw_reset();
    wsel(8'h38); wdat(32'd10);
    wsel(8'h39); wdat(32'd0);
    wsel(8'h00); wdat(32'h1000_0000);
    set_sum(8'h40, 32'hFFFF, 0, 0, 0, 0, 0);
    wsel(8'h01); wdat(32'hC000_0000);
    set_sum(8'h44, 32'h8, 32'h8000_8000, 32'hF0F0_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_arm();
    chk("R8 arm starts in state 0", state_o, 0);
    k_trig = 0; d11 = 1'bx; d12 = 1'bx;
    for (int k = 1; k <= 40; k++) begin
      tick(1);
      if (k == 11) d11 = tmr_done_o[0];
      if (k == 12) d12 = tmr_done_o[0];
      if (trig_o && k_trig == 0) k_trig = k;
    end
    chk("R7 timer done not before limit", d11, 0);
    chk("R7 timer done after limit", d12, 1);
    chk("R7 trigger cycle via timer", k_trig, 13);
    chk("R7 done held", tmr_done_o[0], 1);
    chk("R7 timer1 untouched", tmr_done_o[1], 0);

    // R8 arm gating and abort
    do_arm();
    chk("R8 arm ignored without abort", run_o, 0);
    do_abort();
    chk("R8 abort clears timers", tmr_done_o, 0);
    chk("R8 abort state", state_o, 0);
    do_arm();
    chk("R8 arm after abort", run_o, 1);
    tick(1);
    do_abort();
    chk("R8 abort stops run", run_o, 0);
    chk("R8 abort returns to state 0", state_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule